// File: doc/BRIEF.md
# Linked-page transmit record fetcher

This block reads outgoing CAN messages from a transmit area in host memory and passes them, one 32-bit word at a time, to a CAN transmitter over a valid/ready stream. The transmit area is split into fixed-size pages (2 KB by default; two of them make a 4 KB area). Records are packed one after another inside a page. Each record starts with a header word that gives its size and its type. A record of the link type does not go to the transmitter. It holds a 64-bit address, and fetching continues from that address, so the pages form a chain that the host can close into a loop.

The host controls the block through a small register port. It loads the start address as two 32-bit halves. It starts and stops the fetcher with a halt bit that has separate set and clear registers. For each frame it places in memory, it adds to a pending-frame accumulator. The fetcher reads memory through a word-read port that allows one request in flight. It pulses a link event each time it follows a link record, so that the interrupt logic can tell the host to reclaim a page. If a header is malformed, the fetcher records a sticky fault and stops until the halt bit is set again.

Top module: `txchain_fetch`

## Requirements
- R1: After reset, the halt bit is set. No memory request, no stream beat, no link event and no fault is present.
- R2: The register port selects its targets with `csr_sel`: 0 is halt-set, 1 is halt-clear, 2 is base low, 3 is base high, 4 is pending-add. Writing a value with bit 17 set to halt-set sets the halt bit. Writing a value with bit 17 set to halt-clear clears it. Once the halt bit is cleared, fetching starts at the byte address {base high, base low}.
- R3: A write to pending-add adds the written value to the pending count, which saturates at its maximum. The block reads no record header while the count is zero. Each message record it forwards consumes exactly one count.
- R4: In a header word, bits 15:0 give the record size in bytes and bits 31:16 give the type. The next record starts at the header address plus the size rounded up to a multiple of 4.
- R5: A message record (any type other than 0x1001) goes out as ceil(size/4) beats: the header word first, then the following words in address order. `rec_last` is set on the final beat only. A beat stays stable while `rec_ready` is low.
- R6: A record of type 0x1001 is a link record. The word at +4 is the low half and the word at +8 is the high half of the next fetch address. Following a link record produces no stream beat and consumes no pending count.
- R7: Each link record that is followed raises `link_evt` for exactly one cycle.
- R8: A header with size below 4, or with an offset in its page plus the rounded size larger than the page size, sets `fault`. The fault is sticky. While it is set, no further memory request or beat is issued.
- R9: Setting the halt bit aborts any record in progress. It returns the fetch address to the base, clears the fault and holds the pending count at zero, so writes to pending-add are ignored while halted. A memory response that is still outstanding is discarded.
- R10: `mem_req` stays asserted with a stable `mem_addr` until `mem_gnt` is seen. Only one read is in flight at a time, and its data arrives on `mem_rvalid`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| csr_wr | input | 1 | Register write strobe |
| csr_sel | input | 3 | Register select |
| csr_wdata | input | 32 | Register write data |
| mem_req | output | 1 | Memory word read request |
| mem_addr | output | ADDR_W | Byte address of the requested word |
| mem_gnt | input | 1 | Request accepted |
| mem_rvalid | input | 1 | Read data valid |
| mem_rdata | input | 32 | Read data |
| rec_valid | output | 1 | Stream beat valid |
| rec_data | output | 32 | Stream beat data |
| rec_last | output | 1 | Final beat of a record |
| rec_ready | input | 1 | Transmitter accepts the beat |
| link_evt | output | 1 | One-cycle pulse when a link record is followed |
| fault | output | 1 | Sticky malformed-record flag |

## Verification
The assertions assume that memory grants a request only while it is asserted and returns exactly one response per grant. They also assume that the base address and every link target are word aligned inside one page-aligned region. The bench memory model grants on a periodic pattern, answers two cycles after each grant, and is loaded with aligned addresses only. The stability checks on held requests and held beats leave out the cycle after a halt is set, because aborting is the allowed way to drop them. The bench issues its halt writes in a way that keeps the other properties in force.

// File: rtl/txchain_pkg.sv
package txchain_pkg;

    localparam int WORD_W   = 32;
    localparam int HALT_BIT = 17;
    localparam logic [15:0] LINK_KIND = 16'h1001;

    typedef enum logic [2:0] {
        CSR_CTL_SET  = 3'd0,
        CSR_CTL_CLR  = 3'd1,
        CSR_BASE_LO  = 3'd2,
        CSR_BASE_HI  = 3'd3,
        CSR_PEND_ADD = 3'd4
    } csr_sel_e;

    typedef enum logic [1:0] {
        PH_HEAD,
        PH_LNK_LO,
        PH_LNK_HI,
        PH_BODY
    } phase_e;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_REQ,
        ST_WAIT,
        ST_SEND,
        ST_HALTED,
        ST_DRAIN
    } walk_st_e;

    typedef struct packed {
        logic [15:0] kind;
        logic [15:0] size;
    } rec_head_t;

    typedef struct packed {
        logic              last;
        logic [WORD_W-1:0] data;
    } beat_t;

    // number of 32-bit words a record of the given byte size occupies
    function automatic logic [16:0] words_of(input logic [15:0] size);
        logic [16:0] s;
        s = {1'b0, size} + 17'd3;
        return s >> 2;
    endfunction

endpackage

// File: rtl/txchain_csr.sv
module txchain_csr
    import txchain_pkg::*;
#(
    parameter int ADDR_W = 64,
    parameter int CNT_W  = 8
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              csr_wr,
    input  logic [2:0]        csr_sel,
    input  logic [WORD_W-1:0] csr_wdata,
    input  logic              take,
    output logic              halt,
    output logic [ADDR_W-1:0] base_addr,
    output logic              pend_nz
);

    localparam int SUM_W = WORD_W + CNT_W + 2;
    localparam logic [SUM_W-1:0] PEND_MAX = SUM_W'((65'd1 << CNT_W) - 65'd1);

    logic              halt_q;
    logic [WORD_W-1:0] lo_q, hi_q;
    logic [CNT_W-1:0]  pend_q, pend_d;
    logic [SUM_W-1:0]  sum;
    logic [63:0]       wide;

    always_comb begin
        sum = SUM_W'(pend_q) - SUM_W'(take);
        if (csr_wr && csr_sel == CSR_PEND_ADD)
            sum = sum + SUM_W'(csr_wdata);
        if (halt_q)
            pend_d = '0;
        else if (sum > PEND_MAX)
            pend_d = PEND_MAX[CNT_W-1:0];
        else
            pend_d = sum[CNT_W-1:0];
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            halt_q <= 1'b1;
            lo_q   <= '0;
            hi_q   <= '0;
            pend_q <= '0;
        end else begin
            pend_q <= pend_d;
            if (csr_wr) begin
                case (csr_sel)
                    CSR_CTL_SET: if (csr_wdata[HALT_BIT]) halt_q <= 1'b1;
                    CSR_CTL_CLR: if (csr_wdata[HALT_BIT]) halt_q <= 1'b0;
                    CSR_BASE_LO: lo_q <= csr_wdata;
                    CSR_BASE_HI: hi_q <= csr_wdata;
                    default: ;
                endcase
            end
        end
    end

    assign wide      = {hi_q, lo_q};
    assign base_addr = wide[ADDR_W-1:0];
    assign halt      = halt_q;
    assign pend_nz   = (pend_q != '0);

endmodule

// File: rtl/txchain_walker.sv
module txchain_walker
    import txchain_pkg::*;
#(
    parameter int ADDR_W     = 64,
    parameter int PAGE_BYTES = 2048
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              halt,
    input  logic [ADDR_W-1:0] base_addr,
    input  logic              pend_nz,
    output logic              take,
    output logic              mem_req,
    output logic [ADDR_W-1:0] mem_addr,
    input  logic              mem_gnt,
    input  logic              mem_rvalid,
    input  logic [WORD_W-1:0] mem_rdata,
    output logic              rec_valid,
    output logic [WORD_W-1:0] rec_data,
    output logic              rec_last,
    input  logic              rec_ready,
    output logic              link_evt,
    output logic              fault
);

    localparam int OFF_W  = $clog2(PAGE_BYTES);
    localparam int SPAN_W = OFF_W + 20;

    walk_st_e          st;
    phase_e            ph;
    logic [ADDR_W-1:0] fetch_addr;
    logic [16:0]       remain;
    beat_t             beat;
    logic [WORD_W-1:0] lnk_lo;
    logic              link_q, fault_q;

    rec_head_t         head;
    logic [16:0]       words;
    logic [SPAN_W-1:0] span;
    logic              head_bad, is_link;
    logic [63:0]       target;

    always_comb begin
        head     = rec_head_t'(mem_rdata);
        words    = words_of(head.size);
        span     = SPAN_W'(fetch_addr[OFF_W-1:0]) + (SPAN_W'(words) << 2);
        head_bad = (head.size < 16'd4) || (span > SPAN_W'(PAGE_BYTES));
        is_link  = (head.kind == LINK_KIND);
        target   = {mem_rdata, lnk_lo};
    end

    assign take = !halt && st == ST_WAIT && mem_rvalid && ph == PH_HEAD
                  && !head_bad && !is_link;

    always_ff @(posedge clk) begin
        if (rst) begin
            st         <= ST_IDLE;
            ph         <= PH_HEAD;
            fetch_addr <= '0;
            remain     <= '0;
            beat       <= '0;
            lnk_lo     <= '0;
            link_q     <= 1'b0;
            fault_q    <= 1'b0;
        end else begin
            link_q <= 1'b0;
            if (halt) begin
                fetch_addr <= base_addr;
                fault_q    <= 1'b0;
                ph         <= PH_HEAD;
                if (((st == ST_WAIT || st == ST_DRAIN) && !mem_rvalid)
                    || (st == ST_REQ && mem_gnt))
                    st <= ST_DRAIN;
                else
                    st <= ST_IDLE;
            end else begin
                case (st)
                    ST_IDLE: if (pend_nz) begin
                        ph <= PH_HEAD;
                        st <= ST_REQ;
                    end
                    ST_REQ: if (mem_gnt) st <= ST_WAIT;
                    ST_WAIT: if (mem_rvalid) begin
                        case (ph)
                            PH_HEAD: begin
                                if (head_bad) begin
                                    fault_q <= 1'b1;
                                    st      <= ST_HALTED;
                                end else if (is_link) begin
                                    fetch_addr <= fetch_addr + ADDR_W'(4);
                                    ph         <= PH_LNK_LO;
                                    st         <= ST_REQ;
                                end else begin
                                    fetch_addr <= fetch_addr + ADDR_W'(4);
                                    beat       <= '{last: (words == 17'd1), data: mem_rdata};
                                    remain     <= words - 17'd1;
                                    st         <= ST_SEND;
                                end
                            end
                            PH_LNK_LO: begin
                                lnk_lo     <= mem_rdata;
                                fetch_addr <= fetch_addr + ADDR_W'(4);
                                ph         <= PH_LNK_HI;
                                st         <= ST_REQ;
                            end
                            PH_LNK_HI: begin
                                fetch_addr <= target[ADDR_W-1:0];
                                link_q     <= 1'b1;
                                ph         <= PH_HEAD;
                                st         <= ST_IDLE;
                            end
                            default: begin
                                fetch_addr <= fetch_addr + ADDR_W'(4);
                                beat       <= '{last: (remain == 17'd1), data: mem_rdata};
                                remain     <= remain - 17'd1;
                                st         <= ST_SEND;
                            end
                        endcase
                    end
                    ST_SEND: if (rec_ready) begin
                        if (beat.last) begin
                            st <= ST_IDLE;
                        end else begin
                            ph <= PH_BODY;
                            st <= ST_REQ;
                        end
                    end
                    ST_DRAIN: if (mem_rvalid) st <= ST_IDLE;
                    default: ;
                endcase
            end
        end
    end

    assign mem_req   = (st == ST_REQ);
    assign mem_addr  = fetch_addr;
    assign rec_valid = (st == ST_SEND);
    assign rec_data  = beat.data;
    assign rec_last  = beat.last;
    assign link_evt  = link_q;
    assign fault     = fault_q;

endmodule

// File: rtl/txchain_fetch.sv
module txchain_fetch
    import txchain_pkg::*;
#(
    parameter int ADDR_W     = 64,
    parameter int PAGE_BYTES = 2048,
    parameter int CNT_W      = 8
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              csr_wr,
    input  logic [2:0]        csr_sel,
    input  logic [31:0]       csr_wdata,
    output logic              mem_req,
    output logic [ADDR_W-1:0] mem_addr,
    input  logic              mem_gnt,
    input  logic              mem_rvalid,
    input  logic [31:0]       mem_rdata,
    output logic              rec_valid,
    output logic [31:0]       rec_data,
    output logic              rec_last,
    input  logic              rec_ready,
    output logic              link_evt,
    output logic              fault
);

    logic              halt_w;
    logic [ADDR_W-1:0] base_w;
    logic              pend_nz_w;
    logic              take_w;

    txchain_csr #(.ADDR_W(ADDR_W), .CNT_W(CNT_W)) u_csr (
        .clk       (clk),
        .rst       (rst),
        .csr_wr    (csr_wr),
        .csr_sel   (csr_sel),
        .csr_wdata (csr_wdata),
        .take      (take_w),
        .halt      (halt_w),
        .base_addr (base_w),
        .pend_nz   (pend_nz_w)
    );

    txchain_walker #(.ADDR_W(ADDR_W), .PAGE_BYTES(PAGE_BYTES)) u_walk (
        .clk        (clk),
        .rst        (rst),
        .halt       (halt_w),
        .base_addr  (base_w),
        .pend_nz    (pend_nz_w),
        .take       (take_w),
        .mem_req    (mem_req),
        .mem_addr   (mem_addr),
        .mem_gnt    (mem_gnt),
        .mem_rvalid (mem_rvalid),
        .mem_rdata  (mem_rdata),
        .rec_valid  (rec_valid),
        .rec_data   (rec_data),
        .rec_last   (rec_last),
        .rec_ready  (rec_ready),
        .link_evt   (link_evt),
        .fault      (fault)
    );

endmodule

// File: rtl/txchain_fetch_chk.sv
module txchain_fetch_chk #(
    parameter int ADDR_W = 64
) (
    input logic              clk,
    input logic              rst,
    input logic              halt,
    input logic              mem_req,
    input logic              mem_gnt,
    input logic [ADDR_W-1:0] mem_addr,
    input logic              rec_valid,
    input logic              rec_ready,
    input logic [31:0]       rec_data,
    input logic              rec_last,
    input logic              link_evt,
    input logic              fault
);

    assert_req_hold_R10: assert property (@(posedge clk) disable iff (rst)
        mem_req && !mem_gnt && !halt |=> mem_req && $stable(mem_addr));

    assert_beat_hold_R5: assert property (@(posedge clk) disable iff (rst)
        rec_valid && !rec_ready && !halt |=> rec_valid && $stable(rec_data) && $stable(rec_last));

    assert_link_pulse_R7: assert property (@(posedge clk) disable iff (rst)
        link_evt |=> !link_evt);

    assert_link_no_beat_R6: assert property (@(posedge clk) disable iff (rst)
        link_evt |-> !rec_valid);

    assert_fault_quiet_R8: assert property (@(posedge clk) disable iff (rst)
        fault |-> !mem_req && !rec_valid);

    assert_fault_sticky_R8: assert property (@(posedge clk) disable iff (rst)
        fault && !halt |=> fault);

    assert_halt_idle_R9: assert property (@(posedge clk) disable iff (rst)
        halt && $past(halt) |-> !rec_valid && !mem_req);

endmodule

bind txchain_fetch txchain_fetch_chk #(.ADDR_W(ADDR_W)) u_chk (
    .clk       (clk),
    .rst       (rst),
    .halt      (halt_w),
    .mem_req   (mem_req),
    .mem_gnt   (mem_gnt),
    .mem_addr  (mem_addr),
    .rec_valid (rec_valid),
    .rec_ready (rec_ready),
    .rec_data  (rec_data),
    .rec_last  (rec_last),
    .link_evt  (link_evt),
    .fault     (fault)
);

// File: tb/txchain_fetch_test.sv
module txchain_fetch_test;
    import txchain_pkg::*;

    localparam logic [63:0] BASE = 64'h0000_0001_0000_2000;
    localparam logic [31:0] HALT_W = 32'h1 << HALT_BIT;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        csr_wr = 1'b0;
    logic [2:0]  csr_sel = 3'd0;
    logic [31:0] csr_wdata = 32'd0;
    logic        mem_req, mem_gnt, mem_rvalid;
    logic [63:0] mem_addr;
    logic [31:0] mem_rdata;
    logic        rec_valid, rec_last, link_evt, fault;
    logic [31:0] rec_data;
    logic        rec_ready = 1'b0;

    always #10 clk = ~clk;

    txchain_fetch uut (
        .clk(clk), .rst(rst), .csr_wr(csr_wr), .csr_sel(csr_sel), .csr_wdata(csr_wdata),
        .mem_req(mem_req), .mem_addr(mem_addr), .mem_gnt(mem_gnt),
        .mem_rvalid(mem_rvalid), .mem_rdata(mem_rdata),
        .rec_valid(rec_valid), .rec_data(rec_data), .rec_last(rec_last), .rec_ready(rec_ready),
        .link_evt(link_evt), .fault(fault)
    );

    // memory model: periodic grant, data two cycles after grant
    logic [31:0] ram [0:1023];
    logic        gnt_en = 1'b0;
    logic        p1 = 1'b0, p2 = 1'b0;
    logic [63:0] a1 = '0;
    logic [31:0] d2 = '0;
    logic        hold_ready = 1'b0;
    int          cyc = 0;

    assign mem_gnt    = mem_req && gnt_en;
    assign mem_rvalid = p2;
    assign mem_rdata  = d2;

    always @(posedge clk) begin
        cyc       <= cyc + 1;
        gnt_en    <= (cyc % 4) != 2;
        rec_ready <= hold_ready ? 1'b0 : ((cyc % 3) != 1);
        if (rst) begin
            p1 <= 1'b0;
            p2 <= 1'b0;
        end else begin
            p1 <= mem_gnt;
            a1 <= mem_addr;
            p2 <= p1;
            d2 <= ram[a1[11:2]];
        end
    end

    int n_checks = 0;
    int n_bad = 0;
    int n_reads = 0;
    int n_links = 0;
    int halt_recent = 0;
    bit done = 1'b0;
    logic [32:0] exp_q [$];
    logic        prev_wait = 1'b0;
    logic [63:0] prev_addr = '0;

    task automatic check(input bit ok, input string tag, input string what,
                         input longint act, input longint exp);
        n_checks++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s %s: actual=%0h expected=%0h", tag, what, act, exp);
        end
    endtask

    // monitor / scoreboard
    always @(negedge clk) begin
        if (!rst) begin
            if (halt_recent > 0) halt_recent--;
            if (prev_wait && halt_recent == 0)
                check(mem_req && mem_addr == prev_addr, "R10", "held request address",
                      mem_addr, prev_addr);
            prev_wait = mem_req && !mem_gnt;
            prev_addr = mem_addr;
            if (mem_req && mem_gnt) begin
                n_reads++;
                check(mem_addr[63:12] == BASE[63:12] && mem_addr[1:0] == 2'b00, "R2",
                      "read address region", mem_addr, BASE);
            end
            if (link_evt) n_links++;
            if (rec_valid && rec_ready) begin
                if (exp_q.size() == 0) begin
                    check(1'b0, "R5", "unexpected beat", {rec_last, rec_data}, 0);
                end else begin
                    logic [32:0] e;
                    e = exp_q.pop_front();
                    check({rec_last, rec_data} == e, "R5", "beat {last,data}",
                          {rec_last, rec_data}, e);
                end
            end
        end
    end

    // watchdog
    always @(posedge clk) begin
        if (cyc > 150000 && !done) begin
            done = 1'b1;
            n_checks++;
            n_bad++;
            $display("FAIL watchdog: actual=%0d expected=%0d", cyc, 150000);
            $display("  test done: total=%0d bad=%0d", n_checks, n_bad);
            $finish;
        end
    end

    task automatic csr_write(input logic [2:0] sel, input logic [31:0] val);
        @(posedge clk); #1;
        csr_wr = 1'b1; csr_sel = sel; csr_wdata = val;
        if (sel == CSR_CTL_SET) halt_recent = 4;
        @(posedge clk); #1;
        csr_wr = 1'b0;
    endtask

    task automatic expect_rec(input int idx, input int n);
        for (int i = 0; i < n; i++)
            exp_q.push_back({(i == n - 1), ram[idx + i]});
    endtask

    task automatic wait_empty(input string tag);
        int t = 0;
        while ((exp_q.size() != 0 || rec_valid) && t < 3000) begin
            @(negedge clk);
            t++;
        end
        check(exp_q.size() == 0, tag, "expected beats left", exp_q.size(), 0);
        repeat (10) @(negedge clk);
    endtask

    initial begin
        int r0;
        for (int i = 0; i < 1024; i++) ram[i] = 32'd0;
        ram[0]   = 32'h0010_000C; ram[1] = 32'hA1A1_0001; ram[2] = 32'hA2A2_0002;
        ram[3]   = 32'h0020_0005; ram[4] = 32'hB1B1_0003;
        ram[5]   = 32'h0030_0004;
        ram[6]   = 32'h1001_000C; ram[7] = 32'h0000_2800; ram[8] = 32'h0000_0001;
        ram[512] = 32'h0040_0008; ram[513] = 32'hC1C1_0004;

        repeat (5) @(posedge clk);
        #1 rst = 1'b0;
        @(negedge clk);
        check(!mem_req && !rec_valid, "R1", "req/valid after reset", {mem_req, rec_valid}, 0);
        check(!fault && !link_evt, "R1", "fault/link after reset", {fault, link_evt}, 0);

        csr_write(CSR_BASE_LO, BASE[31:0]);
        csr_write(CSR_BASE_HI, BASE[63:32]);
        csr_write(CSR_PEND_ADD, 32'd1);          // ignored while halted (R9)
        repeat (20) @(negedge clk);
        check(n_reads == 0, "R2", "reads while halted", n_reads, 0);
        csr_write(CSR_CTL_CLR, HALT_W);
        repeat (20) @(negedge clk);
        check(n_reads == 0, "R9", "reads with count dropped while halted", n_reads, 0);

        // one frame: rec0, three beats
        expect_rec(0, 3);
        csr_write(CSR_PEND_ADD, 32'd1);
        wait_empty("R5");
        repeat (20) @(negedge clk);
        check(n_reads == 3, "R3", "no header read at count zero", n_reads, 3);

        // two frames: rec1 (size 5 -> 2 beats) and rec2 (size 4 -> 1 beat)
        expect_rec(3, 2);
        expect_rec(5, 1);
        csr_write(CSR_PEND_ADD, 32'd2);
        wait_empty("R4");
        check(n_reads == 6, "R4", "reads after rounded sizes", n_reads, 6);

        // link record then rec4 on the second page
        expect_rec(512, 2);
        csr_write(CSR_PEND_ADD, 32'd1);
        wait_empty("R6");
        check(n_links == 1, "R7", "link event cycles", n_links, 1);
        check(n_reads == 11, "R6", "reads across link", n_reads, 11);

        // undersized record
        ram[514] = 32'h0050_0002;
        r0 = n_reads;
        csr_write(CSR_PEND_ADD, 32'd1);
        repeat (20) @(negedge clk);
        check(fault, "R8", "fault on size below 4", fault, 1);
        check(n_reads == r0 + 1, "R8", "reads after fault", n_reads, r0 + 1);
        repeat (20) @(negedge clk);
        check(fault && n_reads == r0 + 1, "R8", "fault sticky and quiet", n_reads, r0 + 1);

        csr_write(CSR_CTL_SET, HALT_W);
        repeat (3) @(negedge clk);
        check(!fault, "R9", "fault cleared by halt", fault, 0);

        // page-crossing record at base
        ram[0] = 32'h0010_0804;
        r0 = n_reads;
        csr_write(CSR_CTL_CLR, HALT_W);
        csr_write(CSR_PEND_ADD, 32'd1);
        repeat (20) @(negedge clk);
        check(fault, "R8", "fault on page crossing", fault, 1);
        check(n_reads == r0 + 1, "R8", "reads after crossing fault", n_reads, r0 + 1);

        // halt drops pending count and rewinds
        csr_write(CSR_CTL_SET, HALT_W);
        ram[0] = 32'h0010_000C;
        csr_write(CSR_PEND_ADD, 32'd3);
        r0 = n_reads;
        csr_write(CSR_CTL_CLR, HALT_W);
        repeat (20) @(negedge clk);
        check(n_reads == r0, "R9", "count held zero while halted", n_reads, r0);
        expect_rec(0, 3);
        csr_write(CSR_PEND_ADD, 32'd1);
        wait_empty("R9");

        // stalled beat then abort
        hold_ready = 1'b1;
        repeat (2) @(negedge clk);
        csr_write(CSR_PEND_ADD, 32'd1);
        begin
            int t = 0;
            while (!rec_valid && t < 200) begin @(negedge clk); t++; end
        end
        for (int k = 0; k < 3; k++) begin
            check(rec_valid && rec_data == 32'h0020_0005 && !rec_last, "R5",
                  "beat held while not ready", rec_data, 32'h0020_0005);
            @(negedge clk);
        end
        csr_write(CSR_CTL_SET, HALT_W);
        repeat (3) @(negedge clk);
        check(!rec_valid, "R9", "beat dropped on halt", rec_valid, 0);
        exp_q.delete();
        hold_ready = 1'b0;
        csr_write(CSR_CTL_CLR, HALT_W);
        expect_rec(0, 3);
        csr_write(CSR_PEND_ADD, 32'd1);
        wait_empty("R9");

        done = 1'b1;
        $display("  test done: total=%0d bad=%0d", n_checks, n_bad);
        $finish;
    end

endmodule